// File: doc/BRIEF.md
# Strobe-Aligned Write Data Capture

This block captures double-data-rate write data that arrives with a source-synchronous write strobe. It is modelled synchronously: it runs on a 2x clock, so each rising edge of `clk` is one half-cycle ("tick") of the memory clock. On every tick it samples the strobe level and the data bus. A tick with a rising strobe sample after a low one is a rising strobe edge, and a tick with a falling sample after a high one is a falling edge.

A write command marks a tick. After the programmed write latency the block arms a capture window. Inside that window it expects a low preamble on the strobe, then a rising edge. Starting at that rising edge it collects four data words on four consecutive strobe edges. It then expects a low postamble before the strobe returns high. The four words leave the block together as one parallel burst, marked by a one-cycle valid pulse.

Breaches of the preamble, the arrival window, the postamble or the strobe toggling rules each raise their own one-cycle error flag. Commands that arrive while an earlier capture is still running are held in a queue. Each queued command keeps its own timing reference, measured from its own command tick.

Top module: `strobe_wr_capture`

## Requirements
- R1: While reset is high and in the cycle after it is released, `burst_valid` and all four error flags are 0 and `burst_data` is 0.
- R2: The window for the first rising strobe edge covers ticks 2*WL+EARLY_HC to 2*WL+LATE_HC after the command tick, where the command tick is tick 0. The nominal position is 2*WL. A rising edge inside this window starts a capture.
- R3: Word k (k = 0..3) is the `wdata` sampled on tick r+k, where r is the tick of the first rising edge. It appears at `burst_data[k*DW +: DW]`. Data on all other ticks is ignored.
- R4: `burst_valid` is high for exactly one cycle, the cycle after tick r+3. `burst_data` changes only in a cycle in which `burst_valid` is high.
- R5: Preamble rules. The strobe must go from high to low no earlier than tick 2*WL+EARLY_HC-PRE_HC. It must then stay low for at least PRE_HC ticks before the rising edge. If the preamble is too short, or if the strobe never falls before the window closes, `err_preamble` pulses and the burst is dropped.
- R6: `err_window` pulses and the burst is dropped in two cases: a rising edge falls outside the window, or a preamble fall was seen but no rising edge has arrived by the last tick of the window.
- R7: On ticks r+1, r+2 and r+3 the strobe must change level on every tick. If it fails to change, `err_strobe` pulses and the burst is dropped.
- R8: Postamble rule. The strobe must stay low for POST_HC ticks after tick r+3. A high sample before that raises `err_postamble`. The burst has already been delivered at that point and is kept.
- R9: The strobe may change level only during the preamble, the data ticks, the postamble, and its single return to high after a burst or an aborted burst. Every other change of level pulses `err_strobe`.
- R10: Up to QDEPTH pending commands are held in arrival order. Each is timed from its own command tick, so bursts spaced 8 ticks apart are all captured.
- R11: At most one error flag is high in any cycle, and no error flag is high in a cycle in which `burst_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x clock; one rising edge per half memory cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Write command marker for this tick |
| wstrobe | input | 1 | Write strobe level sampled this tick |
| wdata | input | DW | Write data sampled this tick |
| burst_valid | output | 1 | One-cycle pulse marking a completed burst |
| burst_data | output | 4*DW | Four captured words, word 0 in the low bits |
| err_preamble | output | 1 | Preamble missing or too short |
| err_postamble | output | 1 | Strobe rose before the postamble ended |
| err_window | output | 1 | First rising edge outside the arrival window |
| err_strobe | output | 1 | Strobe toggled when it must not, or failed to toggle during data |

## Verification
The assertions take three things for granted about the inputs. The strobe is high while reset is released. No command arrives while the queue is full. The windows of successive commands do not overlap, so each burst ends with its strobe back high before the next burst's preamble starts. The stimulus is built as per-tick timelines that place bursts at least eight ticks apart. Deliberate faults (short or missing preamble, early or late edges, missed data edges, premature postamble, stray toggles) are injected only into isolated timelines. This keeps the queue far from full and leaves the post-error settling ticks free of other traffic.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int BEATS  = 4;
  localparam int SLOT_W = $clog2(BEATS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } cap_state_t;

  typedef struct packed {
    logic pre;
    logic post;
    logic win;
    logic strb;
  } cap_err_t;
endpackage

// File: rtl/swc_cmd_queue.sv
module swc_cmd_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign valid   = (cnt_q != '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/swc_strobe_sampler.sv
module swc_strobe_sampler (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic level,
  output logic rise,
  output logic fall,
  output logic toggle
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe_in;
  end

  assign level  = strobe_in;
  assign rise   = strobe_in & ~prev_q;
  assign fall   = ~strobe_in & prev_q;
  assign toggle = strobe_in ^ prev_q;
endmodule

// File: rtl/swc_capture_fsm.sv
module swc_capture_fsm
  import swc_pkg::*;
#(
  parameter int WL       = 3,
  parameter int PRE_HC   = 2,
  parameter int POST_HC  = 1,
  parameter int EARLY_HC = -1,
  parameter int LATE_HC  = 1,
  parameter int TS_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb,
  input  logic              rise,
  input  logic              fall,
  input  logic              tog,
  input  logic              q_valid,
  input  logic [TS_W-1:0]   head_ts,
  input  logic [TS_W-1:0]   now,
  output logic              pop,
  output logic              cap_en,
  output logic [SLOT_W-1:0] cap_slot,
  output logic              done,
  output cap_err_t          err
);
  localparam int NOM    = 2 * WL;
  localparam int LO     = NOM + EARLY_HC;
  localparam int HI     = NOM + LATE_HC;
  localparam int ARM_M1 = LO - PRE_HC - 1;
  localparam int CW     = $clog2(PRE_HC + POST_HC + 2) + 1;

  localparam logic [TS_W-1:0]   LO_T    = TS_W'(LO);
  localparam logic [TS_W-1:0]   HI_T    = TS_W'(HI);
  localparam logic [TS_W-1:0]   ARM_T   = TS_W'(ARM_M1);
  localparam logic [CW-1:0]     PRE_C   = CW'(PRE_HC);
  localparam logic [CW-1:0]     POST_M1 = CW'(POST_HC - 1);
  localparam logic [SLOT_W-1:0] LAST_SL = SLOT_W'(BEATS - 1);

  cap_state_t        st_q, st_n;
  logic [SLOT_W-1:0] idx_q, idx_n;
  logic              fell_q, fell_n;
  logic [CW-1:0]     low_q, low_n;
  logic [CW-1:0]     post_q, post_n;
  logic              settle_q, settle_n;
  logic [TS_W-1:0]   cur_q, cur_n;
  cap_err_t          err_n, err_q;
  logic [TS_W-1:0]   el_head, el_cur;

  assign el_head  = now - head_ts;
  assign el_cur   = now - cur_q;
  assign cap_slot = (st_q == ST_PRE) ? '0 : idx_q;

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    fell_n   = fell_q;
    low_n    = low_q;
    post_n   = post_q;
    settle_n = settle_q;
    cur_n    = cur_q;
    err_n    = '0;
    pop      = 1'b0;
    cap_en   = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (settle_q) begin
          if (strb) settle_n = 1'b0;
        end else if (tog) begin
          err_n.strb = 1'b1;
        end
        if (q_valid && (el_head >= ARM_T)) begin
          st_n     = ST_PRE;
          pop      = 1'b1;
          cur_n    = head_ts;
          fell_n   = 1'b0;
          low_n    = '0;
          settle_n = 1'b0;
        end
      end
      ST_PRE: begin
        if (rise) begin
          if ((el_cur < LO_T) || (el_cur > HI_T)) begin
            err_n.win = 1'b1;
            st_n      = ST_IDLE;
            settle_n  = 1'b1;
          end else if (!fell_q || (low_q < PRE_C)) begin
            err_n.pre = 1'b1;
            st_n      = ST_IDLE;
            settle_n  = 1'b1;
          end else begin
            cap_en = 1'b1;
            idx_n  = SLOT_W'(1);
            st_n   = ST_DATA;
          end
        end else if (el_cur >= HI_T) begin
          if (fell_q) err_n.win = 1'b1;
          else        err_n.pre = 1'b1;
          st_n     = ST_IDLE;
          settle_n = 1'b1;
        end else if (fall) begin
          fell_n = 1'b1;
          low_n  = CW'(1);
        end else if (!strb && fell_q && (low_q != '1)) begin
          low_n = low_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (!tog) begin
          err_n.strb = 1'b1;
          st_n       = ST_IDLE;
          settle_n   = 1'b1;
        end else begin
          cap_en = 1'b1;
          if (idx_q == LAST_SL) begin
            done   = 1'b1;
            st_n   = ST_POST;
            post_n = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_POST: begin
        if (strb) begin
          err_n.post = 1'b1;
          st_n       = ST_IDLE;
          settle_n   = 1'b1;
        end else if (post_q == POST_M1) begin
          st_n     = ST_IDLE;
          settle_n = 1'b1;
        end else begin
          post_n = post_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      fell_q   <= 1'b0;
      low_q    <= '0;
      post_q   <= '0;
      settle_q <= 1'b1;
      cur_q    <= '0;
      err_q    <= '0;
    end else begin
      st_q     <= st_n;
      idx_q    <= idx_n;
      fell_q   <= fell_n;
      low_q    <= low_n;
      post_q   <= post_n;
      settle_q <= settle_n;
      cur_q    <= cur_n;
      err_q    <= err_n;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/swc_burst_assembler.sv
module swc_burst_assembler
  import swc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic [SLOT_W-1:0]   cap_slot,
  input  logic                done,
  input  logic [DW-1:0]       din,
  output logic                out_valid,
  output logic [BEATS*DW-1:0] out_data
);
  logic [(BEATS-1)*DW-1:0] lower;

  for (genvar k = 0; k < BEATS - 1; k++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (cap_en && (cap_slot == SLOT_W'(k))) word_q <= din;
    end
    assign lower[k*DW +: DW] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (done) out_data <= {din, lower};
    end
  end
endmodule

// File: rtl/strobe_wr_capture.sv
module strobe_wr_capture
  import swc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int WL       = 3,
  parameter int PRE_HC   = 2,
  parameter int POST_HC  = 1,
  parameter int EARLY_HC = -1,
  parameter int LATE_HC  = 1,
  parameter int QDEPTH   = 4,
  parameter int TS_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_cmd,
  input  logic                wstrobe,
  input  logic [DW-1:0]       wdata,
  output logic                burst_valid,
  output logic [BEATS*DW-1:0] burst_data,
  output logic                err_preamble,
  output logic                err_postamble,
  output logic                err_window,
  output logic                err_strobe
);
  logic [TS_W-1:0]   now_q;
  logic [TS_W-1:0]   head_ts;
  logic              q_valid, q_full, q_pop;
  logic              s_lvl, s_rise, s_fall, s_tog;
  logic              cap_en, done;
  logic [SLOT_W-1:0] cap_slot;
  cap_err_t          err;

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  swc_cmd_queue #(.W(TS_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(wr_cmd), .din(now_q), .pop(q_pop),
    .dout(head_ts), .valid(q_valid), .full(q_full)
  );

  swc_strobe_sampler u_samp (
    .clk(clk), .rst(rst), .strobe_in(wstrobe),
    .level(s_lvl), .rise(s_rise), .fall(s_fall), .toggle(s_tog)
  );

  swc_capture_fsm #(
    .WL(WL), .PRE_HC(PRE_HC), .POST_HC(POST_HC),
    .EARLY_HC(EARLY_HC), .LATE_HC(LATE_HC), .TS_W(TS_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .strb(s_lvl), .rise(s_rise), .fall(s_fall), .tog(s_tog),
    .q_valid(q_valid), .head_ts(head_ts), .now(now_q), .pop(q_pop),
    .cap_en(cap_en), .cap_slot(cap_slot), .done(done), .err(err)
  );

  swc_burst_assembler #(.DW(DW)) u_asm (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_slot(cap_slot), .done(done),
    .din(wdata), .out_valid(burst_valid), .out_data(burst_data)
  );

  assign err_preamble  = err.pre;
  assign err_postamble = err.post;
  assign err_window    = err.win;
  assign err_strobe    = err.strb;
endmodule

// File: rtl/strobe_wr_capture_chk.sv
module strobe_wr_capture_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_cmd,
  input logic            q_full,
  input logic            wstrobe,
  input logic [DW-1:0]   wdata,
  input logic            burst_valid,
  input logic [4*DW-1:0] burst_data,
  input logic            err_preamble,
  input logic            err_postamble,
  input logic            err_window,
  input logic            err_strobe
);
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    burst_valid |=> !burst_valid);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !burst_valid |-> $stable(burst_data));

  assert_first_rise_R2: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> ($past(wstrobe, 4) && !$past(wstrobe, 5)));

  assert_first_word_R3: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (burst_data[DW-1:0] == $past(wdata, 4)));

  assert_last_word_R3: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (burst_data[3*DW +: DW] == $past(wdata, 1)));

  assert_post_high_R8: assert property (@(posedge clk) disable iff (rst)
    err_postamble |-> $past(wstrobe));

  assert_one_error_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_preamble, err_postamble, err_window, err_strobe}));

  assert_no_err_with_valid_R11: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> !(err_preamble || err_postamble || err_window || err_strobe));

  assert_no_drop_R10: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |-> !q_full);
endmodule

bind strobe_wr_capture strobe_wr_capture_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .q_full(q_full), .wstrobe(wstrobe),
  .wdata(wdata), .burst_valid(burst_valid), .burst_data(burst_data),
  .err_preamble(err_preamble), .err_postamble(err_postamble),
  .err_window(err_window), .err_strobe(err_strobe)
);

// File: tb/strobe_wr_capture_test.sv
`timescale 1ns/1ps
module strobe_wr_capture_test;
  localparam int DW = 16;
  localparam int TL = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_cmd = 1'b0;
  logic            wstrobe = 1'b1;
  logic [DW-1:0]   wdata = '0;
  logic            burst_valid;
  logic [4*DW-1:0] burst_data;
  logic            err_preamble, err_postamble, err_window, err_strobe;

  always #5 clk = ~clk;

  strobe_wr_capture uut (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wstrobe(wstrobe), .wdata(wdata),
    .burst_valid(burst_valid), .burst_data(burst_data),
    .err_preamble(err_preamble), .err_postamble(err_postamble),
    .err_window(err_window), .err_strobe(err_strobe)
  );

  int tests = 0, fails = 0, m_tests = 0, m_fails = 0;
  int c_pre = 0, c_post = 0, c_win = 0, c_strb = 0, c_val = 0;
  bit finished = 0;

  logic [4*DW-1:0] exp_q[$];
  logic            tl_s [TL];
  logic            tl_c [TL];
  logic [DW-1:0]   tl_d [TL];

  // monitor: scoreboard compare and error pulse counting
  always @(negedge clk) begin
    if (!rst) begin
      if (err_preamble)  c_pre++;
      if (err_postamble) c_post++;
      if (err_window)    c_win++;
      if (err_strobe)    c_strb++;
      if (burst_valid) begin
        logic [4*DW-1:0] e;
        c_val++;
        m_tests++;
        if (exp_q.size() == 0) begin
          m_fails++;
          $display("FAIL R4 unexpected burst actual=%h expected=none", burst_data);
        end else begin
          e = exp_q.pop_front();
          if (burst_data !== e) begin
            m_fails++;
            $display("FAIL R2 R3 burst actual=%h expected=%h", burst_data, e);
          end
        end
        m_tests++;
        if (err_preamble || err_postamble || err_window || err_strobe) begin
          m_fails++;
          $display("FAIL R11 error with valid actual=1 expected=0");
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tl_clear();
    for (int k = 0; k < TL; k++) begin
      tl_s[k] = 1'b1;
      tl_c[k] = 1'b0;
      tl_d[k] = DW'(16'hE000 + k);
    end
  endtask

  // mode: 0 clean, 1 short preamble, 2 early postamble rise, 3 missed data edge, 4 no preamble fall
  task automatic add_burst(int t0, logic [DW-1:0] base, int d, int mode);
    int r;
    logic [DW-1:0] w [4];
    r = t0 + 6 + d;
    tl_c[t0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      w[k] = base + DW'(k * 16'h0111);
      tl_d[r + k] = w[k];
    end
    if (mode != 4) begin
      for (int e = r - 2; e <= r + 4; e++) tl_s[e] = 1'b0;
      tl_s[r] = 1'b1;
      tl_s[r + 2] = 1'b1;
    end
    if (mode == 1) tl_s[r - 2] = 1'b1;
    if (mode == 2) tl_s[r + 4] = 1'b1;
    if (mode == 3) tl_s[r + 2] = 1'b0;
    if ((mode == 0 || mode == 2) && d >= -1 && d <= 1)
      exp_q.push_back({w[3], w[2], w[1], w[0]});
  endtask

  task automatic play(int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      wr_cmd  = tl_c[k];
      wstrobe = tl_s[k];
      wdata   = tl_d[k];
    end
    @(negedge clk);
    wr_cmd  = 1'b0;
    wstrobe = 1'b1;
    wdata   = 16'hDEAD;
    repeat (6) @(negedge clk);
  endtask

  task automatic run(string tag, int len, int n_val, int n_pre, int n_post, int n_win, int n_strb);
    int v0, p0, po0, w0, s0;
    v0 = c_val; p0 = c_pre; po0 = c_post; w0 = c_win; s0 = c_strb;
    play(len);
    check({tag, " bursts"}, c_val - v0, n_val);
    check({tag, " err_preamble"}, c_pre - p0, n_pre);
    check({tag, " err_postamble"}, c_post - po0, n_post);
    check({tag, " err_window"}, c_win - w0, n_win);
    if (n_strb >= 0) check({tag, " err_strobe"}, c_strb - s0, n_strb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", int'(burst_valid), 0);
    check("R1 data in reset", int'(burst_data != '0), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 errors after reset",
          int'(err_preamble | err_postamble | err_window | err_strobe | burst_valid), 0);

    tl_clear(); add_burst(0, 16'h1000, 0, 0);  run("R2 R3 R4 nominal", 20, 1, 0, 0, 0, 0);
    tl_clear(); add_burst(0, 16'h2000, -1, 0); run("R2 early edge ok", 20, 1, 0, 0, 0, 0);
    tl_clear(); add_burst(0, 16'h3000, 1, 0);  run("R2 late edge ok", 20, 1, 0, 0, 0, 0);
    tl_clear(); add_burst(0, 16'h4000, 0, 0); add_burst(8, 16'h5000, 0, 0);
    add_burst(16, 16'h6000, 0, 0);             run("R10 back-to-back", 32, 3, 0, 0, 0, 0);
    tl_clear(); add_burst(0, 16'h7000, 2, 0);  run("R6 too late", 20, 0, 0, 0, 1, -1);
    tl_clear(); add_burst(0, 16'h7100, -2, 0); run("R6 too early", 20, 0, 0, 0, 1, -1);
    tl_clear(); add_burst(0, 16'h7200, 0, 1);  run("R5 short preamble", 20, 0, 1, 0, 0, -1);
    tl_clear(); add_burst(0, 16'h7300, 0, 4);  run("R5 no preamble fall", 20, 0, 1, 0, 0, 0);
    tl_clear(); add_burst(0, 16'h8000, 0, 2);  run("R8 early postamble rise", 20, 1, 0, 1, 0, 0);
    tl_clear(); add_burst(0, 16'h7400, 0, 3);  run("R7 missed data edge", 20, 0, 0, 0, 0, 1);
    tl_clear(); tl_s[5] = 1'b0;                run("R9 stray toggle", 12, 0, 0, 0, 0, 2);
    tl_clear(); add_burst(0, 16'h9000, 0, 0);  run("R3 R11 after faults", 20, 1, 0, 0, 0, 0);
    check("R10 scoreboard drained", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests + m_tests, fails + m_fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests + m_tests + 1, fails + m_fails + 1);
      $finish;
    end
  end
endmodule